// File: doc/BRIEF.md
# Inbound Address Translation Window Bank

This block turns 64-bit addresses arriving from a serial fabric into 64-bit local-memory addresses. It holds a parameterised set of windows (eight by default). Each window has a base, a power-of-two size, a translated target and an enable. Software programs the windows through a 32-bit register port. Writes are registered and reads are combinational.

A lookup presents an address with a valid strobe. Every enabled window compares the address in parallel. The lowest-numbered window that matches supplies the result. One cycle later the block returns the hit flag, the index of the winning window and the translated address. The translated address is the window's target with the address offset inside the window carried through. When no window matches, the block reports a miss.

Top module: `inb_xlate_bank`

## Requirements
- R1: Register address bits [7:5] select the window and bits [4:0] select the byte offset inside that window's block, so the blocks sit 0x20 apart. The offsets are: 0x00 lower base, 0x04 upper base, 0x08 size, 0x0C lower target, 0x10 upper target. A write followed by a read at the same address returns the stored fields.
- R2: In the lower base register, bit 0 is the window enable and bits [31:12] are base address bits [31:12]. Bits [11:1] are not stored and read as zero. The upper base register stores all 32 bits, which are address bits [63:32].
- R3: The size register keeps a 5-bit code in bits [12:8]. The window spans 2^(code+12) bytes, so code 0 is 4 KiB. All other bits of the size register read as zero.
- R4: The lower target register keeps bits [31:12]. Bits [11:0] are dropped and read as zero. The upper target register stores all 32 bits, which are target bits [63:32].
- R5: After reset, every register reads zero and every window is disabled.
- R6: An address hits a window when the window is enabled and the address equals the 64-bit base in every bit above the low (code+12) bits.
- R7: On a hit, the output address is the 64-bit target with its low (code+12) bits replaced by the same bits of the incoming address.
- R8: When several enabled windows hit, the window with the lowest index wins, and its index is reported on the 3-bit window output.
- R9: On a miss, the valid output is high, while the hit flag, the window index and the address output are all zero.
- R10: The valid output follows the lookup valid input one cycle later. In a cycle with no result, the hit flag, the index and the address output are all zero.
- R11: A lookup sampled at the same clock edge as a register write uses the old settings. A lookup sampled at the next edge uses the new settings.
- R12: Any offset other than the five listed reads as zero, including offsets that are not word aligned. A write to such an offset changes nothing.
- R13: Writing zero to a window's lower base register disables that window. Later lookups that used to hit it then miss, or fall through to a higher-numbered window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address (window index and offset) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| lkValid | input | 1 | Lookup request valid |
| lkAddr | input | 64 | Fabric address to translate |
| outValid | output | 1 | Lookup result valid, one cycle after lkValid |
| outHit | output | 1 | A window matched |
| outWin | output | 3 | Index of the winning window |
| outAddr | output | 64 | Translated local address |

## Verification
The bench targets several corner cases, and a faulty design shows itself on each:
- **Window edges.** Addresses just below the base, the last byte of the window and the first byte after it are all probed. A wrong mask width, such as being off by one in the code-to-shift conversion, hits one byte or one window too far, or carries the wrong low bits into the output.
- **Overlap.** Windows are made to overlap by nesting a small window inside a much larger one. A reversed priority encoder then reports the larger, higher-numbered window.
- **Write and lookup on the same edge.** A write and a lookup are issued together. A design that forwards write data would use the new settings one cycle early.
- **Register read-back.** Junk is written to the unstored low bits, the unused size bits and the unimplemented offsets. A design that keeps those bits, or aliases those offsets onto real registers, returns non-zero data.

// File: rtl/inb_xlate_pkg.sv
package inb_xlate_pkg;

  localparam int DATA_W     = 32;
  localparam int XADDR_W    = 64;
  localparam int OFS_W      = 5;
  localparam int PAGE_SHIFT = 12;
  localparam int CODE_W     = 5;
  localparam int PAGE_W     = DATA_W - PAGE_SHIFT;

  localparam logic [OFS_W-1:0] OFS_BASE_LO = 5'h00;
  localparam logic [OFS_W-1:0] OFS_BASE_HI = 5'h04;
  localparam logic [OFS_W-1:0] OFS_SIZE    = 5'h08;
  localparam logic [OFS_W-1:0] OFS_TGT_LO  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_TGT_HI  = 5'h10;

  localparam int CODE_LSB = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrSize;
    logic wrTgtLo;
    logic wrTgtHi;
    logic lkTake;
  } ctlStrobe_t;

  // one window's programmed state
  typedef struct packed {
    logic              en;
    logic [DATA_W-1:0] baseHi;
    logic [PAGE_W-1:0] baseLo;
    logic [CODE_W-1:0] sizeCode;
    logic [DATA_W-1:0] tgtHi;
    logic [PAGE_W-1:0] tgtLo;
  } winCfg_t;

endpackage

// File: rtl/inb_xlate_ctrl.sv
module inb_xlate_ctrl
  import inb_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW = WIN_W + OFS_W
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              lkValid,
  output ctlStrobe_t        strobe,
  output logic [NUM_WIN-1:0] winSel,
  output logic              inRange,
  output logic [WIN_W-1:0]  winIdx,
  output logic [OFS_W-1:0]  ofs
);

  logic wrOk;

  assign winIdx  = regAddr[REG_AW-1:OFS_W];
  assign ofs     = regAddr[OFS_W-1:0];
  assign inRange = ({1'b0, winIdx} < (WIN_W+1)'(NUM_WIN));
  assign wrOk    = regWrEn && inRange;

  always_comb begin
    strobe          = '0;
    strobe.wrBaseLo = wrOk && (ofs == OFS_BASE_LO);
    strobe.wrBaseHi = wrOk && (ofs == OFS_BASE_HI);
    strobe.wrSize   = wrOk && (ofs == OFS_SIZE);
    strobe.wrTgtLo  = wrOk && (ofs == OFS_TGT_LO);
    strobe.wrTgtHi  = wrOk && (ofs == OFS_TGT_HI);
    strobe.lkTake   = lkValid;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : gSel
    assign winSel[w] = (winIdx == WIN_W'(w));
  end

endmodule

// File: rtl/inb_xlate_match.sv
module inb_xlate_match
  import inb_xlate_pkg::*;
(
  input  winCfg_t             cfg,
  input  logic [XADDR_W-1:0]  lkAddr,
  output logic                hit,
  output logic [XADDR_W-1:0]  xlAddr
);

  localparam int SH_W = $clog2(XADDR_W) + 1;

  logic [SH_W-1:0]    shiftAmt;
  logic [XADDR_W-1:0] lowMask;
  logic [XADDR_W-1:0] baseFull;
  logic [XADDR_W-1:0] tgtFull;

  assign shiftAmt = SH_W'(cfg.sizeCode) + SH_W'(PAGE_SHIFT);
  assign lowMask  = (XADDR_W'(1) << shiftAmt) - XADDR_W'(1);
  assign baseFull = {cfg.baseHi, cfg.baseLo, {PAGE_SHIFT{1'b0}}};
  assign tgtFull  = {cfg.tgtHi, cfg.tgtLo, {PAGE_SHIFT{1'b0}}};

  assign hit    = cfg.en && (((lkAddr ^ baseFull) & ~lowMask) == '0);
  assign xlAddr = (tgtFull & ~lowMask) | (lkAddr & lowMask);

endmodule

// File: rtl/inb_xlate_dp.sv
module inb_xlate_dp
  import inb_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_WIN-1:0] winSel,
  input  logic               inRange,
  input  logic [WIN_W-1:0]   winIdx,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [XADDR_W-1:0] lkAddr,
  output logic               outValid,
  output logic               outHit,
  output logic [WIN_W-1:0]   outWin,
  output logic [XADDR_W-1:0] outAddr
);

  winCfg_t            cfg    [NUM_WIN];
  logic [NUM_WIN-1:0] hitVec;
  logic [XADDR_W-1:0] xlVec  [NUM_WIN];
  logic               anyHit;
  logic [WIN_W-1:0]   selIdx;
  logic [XADDR_W-1:0] selAddr;
  winCfg_t            rdCfg;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WIN; w++) cfg[w] <= '0;
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (winSel[w]) begin
          if (strobe.wrBaseLo) begin
            cfg[w].en     <= regWrData[0];
            cfg[w].baseLo <= regWrData[DATA_W-1:PAGE_SHIFT];
          end
          if (strobe.wrBaseHi) cfg[w].baseHi   <= regWrData;
          if (strobe.wrSize)   cfg[w].sizeCode <= regWrData[CODE_LSB+CODE_W-1:CODE_LSB];
          if (strobe.wrTgtLo)  cfg[w].tgtLo    <= regWrData[DATA_W-1:PAGE_SHIFT];
          if (strobe.wrTgtHi)  cfg[w].tgtHi    <= regWrData;
        end
      end
    end
  end

  // parallel window compare
  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    inb_xlate_match match_i (
      .cfg    (cfg[w]),
      .lkAddr (lkAddr),
      .hit    (hitVec[w]),
      .xlAddr (xlVec[w])
    );
  end

  // lowest index wins
  always_comb begin
    anyHit  = 1'b0;
    selIdx  = '0;
    selAddr = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        anyHit  = 1'b1;
        selIdx  = WIN_W'(w);
        selAddr = xlVec[w];
      end
    end
  end

  // result stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outWin   <= '0;
      outAddr  <= '0;
    end else begin
      outValid <= strobe.lkTake;
      if (strobe.lkTake && anyHit) begin
        outHit  <= 1'b1;
        outWin  <= selIdx;
        outAddr <= selAddr;
      end else begin
        outHit  <= 1'b0;
        outWin  <= '0;
        outAddr <= '0;
      end
    end
  end

  // read mux
  always_comb begin
    rdCfg     = inRange ? cfg[winIdx] : '0;
    regRdData = '0;
    if (inRange) begin
      unique case (ofs)
        OFS_BASE_LO: regRdData = {rdCfg.baseLo, {(PAGE_SHIFT-1){1'b0}}, rdCfg.en};
        OFS_BASE_HI: regRdData = rdCfg.baseHi;
        OFS_SIZE:    regRdData = DATA_W'({rdCfg.sizeCode, {CODE_LSB{1'b0}}});
        OFS_TGT_LO:  regRdData = {rdCfg.tgtLo, {PAGE_SHIFT{1'b0}}};
        OFS_TGT_HI:  regRdData = rdCfg.tgtHi;
        default:     regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/inb_xlate_bank.sv
module inb_xlate_bank
  import inb_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW = WIN_W + OFS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               lkValid,
  input  logic [XADDR_W-1:0] lkAddr,
  output logic               outValid,
  output logic               outHit,
  output logic [WIN_W-1:0]   outWin,
  output logic [XADDR_W-1:0] outAddr
);

  ctlStrobe_t         strobe;
  logic [NUM_WIN-1:0] winSel;
  logic               inRange;
  logic [WIN_W-1:0]   winIdx;
  logic [OFS_W-1:0]   ofs;

  inb_xlate_ctrl #(.NUM_WIN(NUM_WIN)) ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .lkValid (lkValid),
    .strobe  (strobe),
    .winSel  (winSel),
    .inRange (inRange),
    .winIdx  (winIdx),
    .ofs     (ofs)
  );

  inb_xlate_dp #(.NUM_WIN(NUM_WIN)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .winSel    (winSel),
    .inRange   (inRange),
    .winIdx    (winIdx),
    .ofs       (ofs),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .lkAddr    (lkAddr),
    .outValid  (outValid),
    .outHit    (outHit),
    .outWin    (outWin),
    .outAddr   (outAddr)
  );

endmodule

// File: rtl/inb_xlate_bank_chk.sv
module inb_xlate_bank_chk
  import inb_xlate_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW = WIN_W + OFS_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [REG_AW-1:0]  regAddr,
  input logic [DATA_W-1:0]  regRdData,
  input logic               lkValid,
  input logic [XADDR_W-1:0] lkAddr,
  input logic               outValid,
  input logic               outHit,
  input logic [WIN_W-1:0]   outWin,
  input logic [XADDR_W-1:0] outAddr
);

  logic [OFS_W-1:0] chkOfs;
  logic             chkImpl;
  assign chkOfs  = regAddr[OFS_W-1:0];
  assign chkImpl = (chkOfs == OFS_BASE_LO) || (chkOfs == OFS_BASE_HI) ||
                   (chkOfs == OFS_SIZE) || (chkOfs == OFS_TGT_LO) ||
                   (chkOfs == OFS_TGT_HI);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> outValid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!outValid && !outHit && outWin == '0 && outAddr == '0));

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outHit) |-> (outWin == '0 && outAddr == '0));

  p_offset_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (!outHit || outAddr[PAGE_SHIFT-1:0] == $past(lkAddr[PAGE_SHIFT-1:0])));

  p_unimpl_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !chkImpl |-> (regRdData == '0));

  p_base_lo_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chkOfs == OFS_BASE_LO) |-> (regRdData[PAGE_SHIFT-1:1] == '0));

  p_size_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chkOfs == OFS_SIZE) |-> (regRdData[DATA_W-1:CODE_LSB+CODE_W] == '0 &&
                              regRdData[CODE_LSB-1:0] == '0));

  p_tgt_lo_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chkOfs == OFS_TGT_LO) |-> (regRdData[PAGE_SHIFT-1:0] == '0));

endmodule

bind inb_xlate_bank inb_xlate_bank_chk #(.NUM_WIN(NUM_WIN)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .lkValid   (lkValid),
  .lkAddr    (lkAddr),
  .outValid  (outValid),
  .outHit    (outHit),
  .outWin    (outWin),
  .outAddr   (outAddr)
);

// File: tb/inb_xlate_bank_tb_top.sv
module inb_xlate_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [7:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        lkValid;
  logic [63:0] lkAddr;
  logic        outValid;
  logic        outHit;
  logic [2:0]  outWin;
  logic [63:0] outAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  inb_xlate_bank dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lkValid(lkValid),
    .lkAddr(lkAddr), .outValid(outValid), .outHit(outHit),
    .outWin(outWin), .outAddr(outAddr)
  );

  // behavioural reference state
  bit          mEn   [8];
  logic [31:0] mBHi  [8];
  logic [31:0] mBLo  [8];
  logic [4:0]  mCode [8];
  logic [31:0] mTHi  [8];
  logic [31:0] mTLo  [8];

  task automatic mReset();
    for (int i = 0; i < 8; i++) begin
      mEn[i] = 0; mBHi[i] = 0; mBLo[i] = 0; mCode[i] = 0; mTHi[i] = 0; mTLo[i] = 0;
    end
  endtask

  function automatic logic [31:0] mRead(input logic [7:0] a);
    int i = int'(a[7:5]);
    case (a[4:0])
      5'h00:   return {mBLo[i][31:12], 11'b0, mEn[i]};
      5'h04:   return mBHi[i];
      5'h08:   return {19'b0, mCode[i], 8'b0};
      5'h0C:   return {mTLo[i][31:12], 12'b0};
      5'h10:   return mTHi[i];
      default: return 32'h0;
    endcase
  endfunction

  task automatic mWrite(input logic [7:0] a, input logic [31:0] d);
    int i = int'(a[7:5]);
    case (a[4:0])
      5'h00: begin mEn[i] = d[0]; mBLo[i] = {d[31:12], 12'b0}; end
      5'h04: mBHi[i] = d;
      5'h08: mCode[i] = d[12:8];
      5'h0C: mTLo[i] = {d[31:12], 12'b0};
      5'h10: mTHi[i] = d;
      default: ;
    endcase
  endtask

  task automatic mLookup(input logic [63:0] a, output bit h, output logic [2:0] w,
                         output logic [63:0] x);
    h = 0; w = 0; x = 0;
    for (int i = 0; i < 8; i++) begin
      int sz = int'(mCode[i]) + 12;
      logic [63:0] span = 64'd1 << sz;
      logic [63:0] base = {mBHi[i], mBLo[i]};
      logic [63:0] tgt  = {mTHi[i], mTLo[i]};
      if (!h && mEn[i] && (a / span) == (base / span)) begin
        h = 1; w = 3'(i);
        x = (tgt / span) * span + (a % span);
      end
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: drive, check read, clock, check result
  task automatic cyc(input string req, input bit wr, input logic [7:0] a,
                     input logic [31:0] d, input bit lv, input logic [63:0] la);
    bit eh; logic [2:0] ew; logic [63:0] ex;
    regWrEn = wr; regAddr = a; regWrData = d; lkValid = lv; lkAddr = la;
    #2;
    check(req, "read data", 64'(regRdData), 64'(mRead(a)));
    mLookup(la, eh, ew, ex);
    if (!lv) begin eh = 0; ew = 0; ex = 0; end
    @(posedge clk);
    if (wr) mWrite(a, d);
    #2;
    check(req, "outValid", 64'(outValid), 64'(lv));
    check(req, "outHit",   64'(outHit),   64'(eh));
    check(req, "outWin",   64'(outWin),   64'(ew));
    check(req, "outAddr",  outAddr,       ex);
  endtask

  task automatic wr(input string req, input int win, input logic [4:0] o, input logic [31:0] d);
    cyc(req, 1, {3'(win), o}, d, 0, 64'h0);
  endtask

  task automatic rd(input string req, input int win, input logic [4:0] o);
    cyc(req, 0, {3'(win), o}, 32'h0, 0, 64'h0);
  endtask

  task automatic lk(input string req, input logic [63:0] a);
    cyc(req, 0, 8'h00, 32'h0, 1, a);
  endtask

  initial begin
    mReset();
    rstN = 0; regWrEn = 0; regAddr = 0; regWrData = 0; lkValid = 0; lkAddr = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    #1;
    // R5: reset state
    check("R5", "outValid after reset", 64'(outValid), 64'h0);
    for (int w = 0; w < 8; w++)
      for (int o = 0; o < 32; o += 4) rd("R5", w, 5'(o));
    lk("R5", 64'h0);
    lk("R9", 64'h0000_0012_3456_789A);

    // window 2: 64 KiB at 0x12_3456_0000 -> 0xAB_CDEF_0000
    wr("R3", 2, 5'h08, 32'h0000_0400);
    wr("R4", 2, 5'h10, 32'h0000_00AB);
    wr("R4", 2, 5'h0C, 32'hCDEF_0FFF);
    rd("R4", 2, 5'h0C);
    wr("R2", 2, 5'h04, 32'h0000_0012);
    wr("R2", 2, 5'h00, 32'h3456_0FFF);
    rd("R2", 2, 5'h00);
    rd("R1", 2, 5'h04);
    rd("R1", 2, 5'h10);
    lk("R7", 64'h0000_0012_3456_789A);
    check("R7", "hand translated", outAddr, 64'h0000_00AB_CDEF_789A);
    check("R6", "hand index", 64'(outWin), 64'd2);
    lk("R6", 64'h0000_0012_3456_0000);
    lk("R6", 64'h0000_0012_3456_FFFF);
    check("R6", "last byte hits", 64'(outHit), 64'd1);
    lk("R6", 64'h0000_0012_3457_0000);
    check("R6", "byte past end misses", 64'(outHit), 64'd0);
    lk("R6", 64'h0000_0012_3455_FFFF);
    lk("R6", 64'h0000_0013_3456_789A);

    // R3: junk in size register keeps only the code
    wr("R3", 6, 5'h08, 32'hFFFF_FFFF);
    rd("R3", 6, 5'h08);
    check("R3", "size readback", 64'(regRdData), 64'h0000_1F00);

    // R12: unimplemented and unaligned offsets
    for (int o = 5'h14; o < 32; o += 4) wr("R12", 2, 5'(o), 32'hFFFF_FFFF);
    wr("R12", 2, 5'h01, 32'hFFFF_FFFF);
    wr("R12", 2, 5'h0E, 32'hFFFF_FFFF);
    for (int o = 0; o < 32; o++) rd("R12", 2, 5'(o));
    lk("R12", 64'h0000_0012_3456_789A);

    // R8: 4 GiB window 5 covers window 2; 4 KiB window 1 inside window 2
    wr("R8", 5, 5'h08, 32'h0000_1400);
    wr("R8", 5, 5'h04, 32'h0000_0012);
    wr("R8", 5, 5'h10, 32'h0000_7777);
    wr("R8", 5, 5'h00, 32'h0000_0001);
    lk("R8", 64'h0000_0012_3456_789A);
    check("R8", "lower index wins", 64'(outWin), 64'd2);
    lk("R8", 64'h0000_0012_9000_0004);
    check("R8", "only big window", 64'(outWin), 64'd5);
    wr("R8", 1, 5'h04, 32'h0000_0012);
    wr("R8", 1, 5'h0C, 32'h0000_5000);
    wr("R8", 1, 5'h00, 32'h3456_7001);
    lk("R8", 64'h0000_0012_3456_789A);
    check("R8", "window 1 wins", 64'(outWin), 64'd1);
    check("R7", "4 KiB translate", outAddr, 64'h0000_0000_0000_589A);

    // R11 + R13: disable window 1 on the same edge as a lookup
    cyc("R11", 1, {3'd1, 5'h00}, 32'h0, 1, 64'h0000_0012_3456_789A);
    check("R11", "old settings used", 64'(outWin), 64'd1);
    lk("R13", 64'h0000_0012_3456_789A);
    check("R13", "falls to window 2", 64'(outWin), 64'd2);
    wr("R13", 2, 5'h00, 32'h0);
    wr("R13", 5, 5'h00, 32'h0);
    lk("R13", 64'h0000_0012_3456_789A);
    check("R13", "all disabled", 64'(outHit), 64'd0);

    // top window: code 31 at high address, index 7
    wr("R6", 7, 5'h08, 32'h0000_1F00);
    wr("R6", 7, 5'h04, 32'hFFFF_F800);
    wr("R6", 7, 5'h10, 32'h0000_0800);
    wr("R6", 7, 5'h00, 32'h0000_0001);
    lk("R7", 64'hFFFF_FFFF_FFFF_FFFF);
    lk("R6", 64'hFFFF_F7FF_FFFF_FFFF);
    wr("R6", 0, 5'h00, 32'h0000_1001);
    lk("R6", 64'h0000_0000_0000_1FFF);
    lk("R6", 64'h0000_0000_0000_2000);
    lk("R10", 64'h0);
    rd("R10", 0, 5'h00);

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int kind = $urandom_range(0, 3);
      logic [63:0] a;
      case ($urandom_range(0, 3))
        0: a = {32'h0000_0012, $urandom()};
        1: a = {$urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'hFFFF_F7FF, $urandom()};
        2: a = {32'h0, 16'h0, 4'h0, 12'($urandom())};
        default: a = {$urandom(), $urandom()};
      endcase
      if (kind == 0) begin
        logic [31:0] d = $urandom();
        if ($urandom_range(0, 1) == 1) d[31:16] = 16'h3456;
        cyc("R1", 1, 8'($urandom()), d, $urandom_range(0, 1) == 1, a);
      end else if (kind == 1) begin
        cyc("R10", 0, 8'($urandom()), 32'h0, 0, a);
      end else begin
        cyc("R6", 0, 8'($urandom()), 32'h0, 1, a);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule